// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block holds the pending service requests of a peripheral with several service sources: a modem-line change, transmit data, good receive data, exception receive data, a parallel-port state machine and a parallel-port data pipeline. Each source pulses one bit of `svc_set`. The block latches the pulse and raises one active-high request line for each of four service classes: receive, transmit, modem and parallel.

The host services a class by pulling that class's active-low acknowledge strobe low. While the strobe is low, the block drives an 8-bit vector and asserts `bus_oe`. The top five bits of the vector come from a host-writable vector register. The bottom three bits carry a type code that tells the host which kind of request it is serving. When the strobe is released, the block clears the request kinds that the vector reported.

The vector register is written and read through a small host port. That port has a chip select, a data strobe, a read/write line, a 7-bit address and 8-bit write data. All inputs are sampled on the rising clock edge. The data bus is modelled as a value `bus_out` plus a separate output enable `bus_oe`.

Top module: `intack_vector_gen`

## Requirements
- R1: After reset the vector register reads 0x00, all four request outputs are low and `bus_oe` is low.
- R2: A write cycle (`cs_n`=0, `ds_n`=0, `rd_wr`=0, `addr`=VEC_ADDR, default 0x2C) stores `wdata` in the vector register. A read cycle (`rd_wr`=1, same address) drives the full register value on `bus_out` with `bus_oe`=1.
- R3: A 1 on `svc_set` bit (0 modem, 1 transmit, 2 receive good, 3 receive exception, 4 parallel state machine, 5 parallel pipeline) at a clock edge raises the matching request output (`irq_rx` for bits 2 and 3, `irq_pp` for bits 4 and 5). The output stays high until the first clock edge at which the serving strobe is sampled high after being sampled low; it is low from that edge onward.
- R4: While a strobe is low, `bus_out[7:3]` equals vector register bits 7:3. `bus_out[2:0]` is 001 for a modem request and 010 for a transmit request.
- R5: During a receive acknowledge the low code is 011 when good data is pending and 111 when only exception data is pending. Good data is reported first, and an unreported exception request stays pending after the strobe is released.
- R6: During a parallel acknowledge the low code is 100 for the state machine alone, 101 for the pipeline alone and 110 for both; releasing the strobe clears exactly the reported sources.
- R7: An acknowledge of a class with nothing pending drives low code 000 and clears no request.
- R8: When several strobes are low together, the served class is receive, then transmit, then modem, then parallel; only the served class is cleared on release.
- R9: `bus_oe` is high only while a strobe is low or a read cycle hits the register; an acknowledge overrides a simultaneous register read on `bus_out`.
- R10: A `svc_set` pulse in the same clock edge that clears that source leaves the request pending.
- R11: A write with `cs_n`=1 or with another address leaves the vector register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_set | input | 6 | Request pulses, one bit per source |
| irq_rx | output | 1 | Receive service request |
| irq_tx | output | 1 | Transmit service request |
| irq_modem | output | 1 | Modem service request |
| irq_pp | output | 1 | Parallel-port service request |
| ack_rx_n | input | 1 | Receive acknowledge strobe, active low |
| ack_tx_n | input | 1 | Transmit acknowledge strobe, active low |
| ack_modem_n | input | 1 | Modem acknowledge strobe, active low |
| ack_pp_n | input | 1 | Parallel acknowledge strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | 1 read, 0 write |
| addr | input | 7 | Register address |
| wdata | input | 8 | Host write data |
| bus_out | output | 8 | Value for the data bus |
| bus_oe | output | 1 | Data bus output enable |

## Verification
The hardest situation to reach is a source pulse that lands on the very clock edge at which a strobe release clears that same source. A small timing slip makes the stimulus test either a plain set or a plain clear, so the set-versus-clear ordering goes unexercised. The bench drives the source pulse on the same falling edge that raises the strobe, so both reach the block at one rising edge. The bench also overlaps strobes, and it mixes good and exception receive data so that one release leaves the exception request pending. Both cases show whether the clear mask follows the code that was actually shown to the host.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int NSRC   = 6;
  localparam int NCLS   = 4;
  localparam int CODE_W = 3;

  localparam int SRC_MODEM = 0;
  localparam int SRC_TX    = 1;
  localparam int SRC_GOOD  = 2;
  localparam int SRC_EXC   = 3;
  localparam int SRC_FSM   = 4;
  localparam int SRC_PIPE  = 5;

  localparam int STB_RX    = 0;
  localparam int STB_TX    = 1;
  localparam int STB_MODEM = 2;
  localparam int STB_PP    = 3;

  typedef enum logic [2:0] {CLS_NONE, CLS_RX, CLS_TX, CLS_MODEM, CLS_PP} cls_e;

  // fixed priority among active strobes
  function automatic cls_e pick_class(input logic [NCLS-1:0] act);
    if (act[STB_RX])         return CLS_RX;
    else if (act[STB_TX])    return CLS_TX;
    else if (act[STB_MODEM]) return CLS_MODEM;
    else if (act[STB_PP])    return CLS_PP;
    else                     return CLS_NONE;
  endfunction

  function automatic logic cls_live(input cls_e c, input logic [NCLS-1:0] act);
    case (c)
      CLS_RX:    return act[STB_RX];
      CLS_TX:    return act[STB_TX];
      CLS_MODEM: return act[STB_MODEM];
      CLS_PP:    return act[STB_PP];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] type_code(input cls_e c, input logic [NSRC-1:0] p);
    case (c)
      CLS_MODEM: return p[SRC_MODEM] ? 3'b001 : 3'b000;
      CLS_TX:    return p[SRC_TX]    ? 3'b010 : 3'b000;
      CLS_RX:    return p[SRC_GOOD]  ? 3'b011 : (p[SRC_EXC] ? 3'b111 : 3'b000);
      CLS_PP: begin
        if (p[SRC_FSM] && p[SRC_PIPE]) return 3'b110;
        else if (p[SRC_FSM])           return 3'b100;
        else if (p[SRC_PIPE])          return 3'b101;
        else                           return 3'b000;
      end
      default:   return 3'b000;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] clear_mask(input logic [CODE_W-1:0] code);
    logic [NSRC-1:0] m;
    m = '0;
    case (code)
      3'b001: m[SRC_MODEM] = 1'b1;
      3'b010: m[SRC_TX]    = 1'b1;
      3'b011: m[SRC_GOOD]  = 1'b1;
      3'b111: m[SRC_EXC]   = 1'b1;
      3'b100: m[SRC_FSM]   = 1'b1;
      3'b101: m[SRC_PIPE]  = 1'b1;
      3'b110: begin
        m[SRC_FSM]  = 1'b1;
        m[SRC_PIPE] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ivg_req_latch.sv
module ivg_req_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign pend[i] = q;

    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !pend[i]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]); // R10
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> $stable(pend[i])); // R3
  end
endmodule

// File: rtl/ivg_host_port.sv
module ivg_host_port #(
  parameter int               ADDR_W   = 7,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] vec_q,
  output logic              rd_hit,
  output logic              wr_hit
);
  logic sel_hit;
  assign sel_hit = !cs_n && !ds_n && (addr == VEC_ADDR);
  assign rd_hit  = sel_hit && rd_wr;
  assign wr_hit  = sel_hit && !rd_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '0;
    else if (wr_hit) vec_q <= wdata;
  end

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (vec_q == $past(wdata))); // R2
  AST_VEC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || addr != VEC_ADDR) |=> $stable(vec_q)); // R11
endmodule

// File: rtl/ivg_ack_ctrl.sv
module ivg_ack_ctrl
  import ivg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   act,
  input  logic [NSRC-1:0]   pend,
  output logic              ack_any,
  output logic [CODE_W-1:0] code,
  output logic [NSRC-1:0]   clr
);
  cls_e              sel, sel_q;
  logic [CODE_W-1:0] code_q;
  logic              ack_done;

  assign sel     = pick_class(act);
  assign ack_any = (sel != CLS_NONE);
  assign code    = type_code(sel, pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= CLS_NONE;
      code_q <= '0;
    end else begin
      sel_q  <= sel;
      code_q <= code;
    end
  end

  // served strobe seen low last edge, high now: the cycle completes
  assign ack_done = (sel_q != CLS_NONE) && !cls_live(sel_q, act);
  assign clr      = ack_done ? clear_mask(code_q) : '0;

  AST_RX_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CLS_RX) |-> (code inside {3'b000, 3'b011, 3'b111})); // R5
  AST_PP_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CLS_PP) |-> (code inside {3'b000, 3'b100, 3'b101, 3'b110})); // R6
  AST_NONE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && code_q == 3'b000) |-> (clr == '0)); // R7
endmodule

// File: rtl/intack_vector_gen.sv
module intack_vector_gen
  import ivg_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   svc_set,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_modem,
  output logic              irq_pp,
  input  logic              ack_rx_n,
  input  logic              ack_tx_n,
  input  logic              ack_modem_n,
  input  logic              ack_pp_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int VEC_HI = DATA_W - CODE_W;

  logic [NSRC-1:0]   pend, clr;
  logic [NCLS-1:0]   act;
  logic              ack_any, rd_hit, wr_hit;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] vec_q;

  assign act[STB_RX]    = !ack_rx_n;
  assign act[STB_TX]    = !ack_tx_n;
  assign act[STB_MODEM] = !ack_modem_n;
  assign act[STB_PP]    = !ack_pp_n;

  ivg_req_latch #(.N(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .set(svc_set), .clr(clr), .pend(pend)
  );

  ivg_ack_ctrl u_ack (
    .clk(clk), .rst_n(rst_n), .act(act), .pend(pend),
    .ack_any(ack_any), .code(code), .clr(clr)
  );

  ivg_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)) u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rd_wr(rd_wr),
    .addr(addr), .wdata(wdata), .vec_q(vec_q), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  assign irq_rx    = pend[SRC_GOOD] | pend[SRC_EXC];
  assign irq_tx    = pend[SRC_TX];
  assign irq_modem = pend[SRC_MODEM];
  assign irq_pp    = pend[SRC_FSM] | pend[SRC_PIPE];

  always_comb begin
    if (ack_any)     bus_out = {vec_q[DATA_W-1:CODE_W], code};
    else if (rd_hit) bus_out = vec_q;
    else             bus_out = '0;
  end
  assign bus_oe = ack_any | rd_hit;

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx_n && ack_tx_n && ack_modem_n && ack_pp_n && cs_n) |-> !bus_oe); // R9
  AST_ACK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_rx_n && ack_tx_n && ack_modem_n && ack_pp_n)
      |-> (bus_out[DATA_W-1:CODE_W] == vec_q[DATA_W-1:CODE_W])); // R4
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rx_n && pend[SRC_GOOD]) |-> (bus_out[CODE_W-1:0] == 3'b011)); // R8
  AST_OE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_tx_n |-> bus_oe); // R9
  wire unused_wr = wr_hit;
endmodule

// File: tb/sim_intack_vector_gen.sv
module sim_intack_vector_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] svc_set = '0;
  logic       irq_rx, irq_tx, irq_modem, irq_pp;
  logic       ack_rx_n = 1'b1, ack_tx_n = 1'b1, ack_modem_n = 1'b1, ack_pp_n = 1'b1;
  logic       cs_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] bus_out;
  logic       bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [6:0] VA = 7'h2C;
  localparam logic [7:0] VEC = 8'hAD;

  always #4 clk = ~clk;

  intack_vector_gen u0 (
    .clk(clk), .rst_n(rst_n), .svc_set(svc_set),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_modem(irq_modem), .irq_pp(irq_pp),
    .ack_rx_n(ack_rx_n), .ack_tx_n(ack_tx_n), .ack_modem_n(ack_modem_n), .ack_pp_n(ack_pp_n),
    .cs_n(cs_n), .ds_n(ds_n), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  // row: {sources[5:0], strobes[3:0] rx,tx,modem,pp from bit0, code[2:0], irq_after[3:0]}
  localparam int NROW = 14;
  localparam logic [16:0] TBL [NROW] = '{
    {6'b000001, 4'b0100, 3'b001, 4'b0000},
    {6'b000010, 4'b0010, 3'b010, 4'b0000},
    {6'b000100, 4'b0001, 3'b011, 4'b0000},
    {6'b001000, 4'b0001, 3'b111, 4'b0000},
    {6'b001100, 4'b0001, 3'b011, 4'b0001},
    {6'b000000, 4'b0001, 3'b111, 4'b0000},
    {6'b010000, 4'b1000, 3'b100, 4'b0000},
    {6'b100000, 4'b1000, 3'b101, 4'b0000},
    {6'b110000, 4'b1000, 3'b110, 4'b0000},
    {6'b000001, 4'b0010, 3'b000, 4'b0100},
    {6'b000010, 4'b0110, 3'b010, 4'b0100},
    {6'b000000, 4'b0100, 3'b001, 4'b0000},
    {6'b010100, 4'b1111, 3'b011, 4'b1000},
    {6'b000000, 4'b1000, 3'b100, 4'b0000}
  };

  function automatic logic [3:0] src_classes(input logic [5:0] s);
    return {s[4] | s[5], s[0], s[1], s[2] | s[3]};
  endfunction

  function automatic logic [3:0] irq_now();
    return {irq_pp, irq_modem, irq_tx, irq_rx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_strobes(input logic [3:0] m);
    ack_rx_n = ~m[0]; ack_tx_n = ~m[1]; ack_modem_n = ~m[2]; ack_pp_n = ~m[3];
  endtask

  task automatic host_write(input logic [6:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    cs_n = ~cs; ds_n = 1'b0; rd_wr = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic host_read(input string tag, input logic [7:0] exp);
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b0; rd_wr = 1'b1; addr = VA;
    #1;
    chk(tag, {23'd0, bus_oe, bus_out}, {23'd0, 1'b1, exp});
    @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 request outputs after reset", {28'd0, irq_now()}, 32'd0);
    chk("R1 bus_oe after reset", {31'd0, bus_oe}, 32'd0);
    host_read("R1 vector register after reset", 8'h00);

    host_write(VA, VEC, 1'b1);
    host_read("R2 register read back", VEC);
    host_write(VA, 8'h33, 1'b0);
    host_read("R11 write with chip select high", VEC);
    host_write(7'h2D, 8'h44, 1'b1);
    host_read("R11 write to other address", VEC);
    @(negedge clk); #1;
    chk("R9 bus idle", {31'd0, bus_oe}, 32'd0);

    // table walk
    exp_irq = 4'b0000;
    for (int r = 0; r < NROW; r++) begin
      logic [5:0] s;
      logic [3:0] stb, after;
      logic [2:0] cd;
      {s, stb, cd, after} = TBL[r];
      @(negedge clk); svc_set = s;
      @(negedge clk); svc_set = '0; #1;
      exp_irq = exp_irq | src_classes(s);
      chk($sformatf("R3 row %0d request raised", r), {28'd0, irq_now()}, {28'd0, exp_irq});
      @(negedge clk); set_strobes(stb); #1;
      chk($sformatf("R4 R5 R6 R7 R8 row %0d vector", r), {23'd0, bus_oe, bus_out},
          {23'd0, 1'b1, VEC[7:3], cd});
      @(negedge clk); set_strobes(4'b0000);
      @(negedge clk); #1;
      exp_irq = after;
      chk($sformatf("R3 row %0d request after release", r), {28'd0, irq_now()}, {28'd0, after});
    end

    // R9: acknowledge wins over a simultaneous register read
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b0; rd_wr = 1'b1; addr = VA; set_strobes(4'b0010); #1;
    chk("R9 ack overrides read", {23'd0, bus_oe, bus_out}, {23'd0, 1'b1, VEC[7:3], 3'b000});
    @(negedge clk); cs_n = 1'b1; ds_n = 1'b1; set_strobes(4'b0000);
    @(negedge clk); #1;
    chk("R9 bus released", {31'd0, bus_oe}, 32'd0);

    // R10: new good-data pulse on the clearing edge
    @(negedge clk); svc_set = 6'b000100;
    @(negedge clk); svc_set = '0; set_strobes(4'b0001); #1;
    chk("R10 vector before release", {24'd0, bus_out}, {24'd0, VEC[7:3], 3'b011});
    @(negedge clk); set_strobes(4'b0000); svc_set = 6'b000100;
    @(negedge clk); svc_set = '0; #1;
    chk("R10 request survives clear", {31'd0, irq_rx}, 32'd1);
    @(negedge clk); set_strobes(4'b0001);
    @(negedge clk); set_strobes(4'b0000);
    @(negedge clk); #1;
    chk("R10 request cleared by second ack", {31'd0, irq_rx}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule